// File: doc/BRIEF.md
# I2C Configuration Target with Nonvolatile Commit

This block is a two-wire bus target that holds the settings of a clock generator: a prescaler register (divider exponent, dither depth select and the powered-down output level) and an address register (three target address bits plus a commit-policy bit). The bus lines are sampled with the system clock, so START, STOP and data bits are all recognised from synchronised edges. The target never stretches the clock. It drives SDA only through an open-drain pull-down output.

A master first sends the address byte. The first data byte of a write sets the register pointer, and every following byte is written at the pointer, which then advances. A read writes the pointer, issues a repeated START and then clocks data out until the master answers with NACK. Pointer value 3Fh is a command that copies every register into the nonvolatile image.

The nonvolatile store is modelled as a register image with a busy timer. Each commit holds the store busy for a fixed number of clock cycles. While it is busy, the target answers every address and data byte with NACK and discards the data. The commit-policy bit selects between committing each prescaler write at once and deferring it until the command. A write to the address register always commits at once.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, the prescaler image reads C0h (bits 7:6 forced to 1, all other bits 0) and the address image reads F0h (bits 7:4 forced to 1, all other bits 0). The working registers equal these images, the store is not busy, and SDA is released.
- R2: An address byte is acknowledged only when its bits 7:4 are 1011b, its bits 3:1 equal address register bits 2:0, and the store is idle. Bit 0 is the direction bit (1 = read). On any other address byte the target NACKs and ignores the bus until the next START or STOP.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is written to the register at the pointer, and the pointer then advances by one. Register 02h keeps bits 5:0, register 0Dh keeps bits 3:0, and writes to any other pointer are ignored.
- R4: Reads return {11b, prescaler bits 5:0} at 02h, {1111b, address bits 3:0} at 0Dh, and FFh at any other pointer. Each master ACK advances the pointer to the next byte. After a master NACK, SDA stays released.
- R5: The divider exponent output equals min(prescaler bits 3:0, 8). Prescaler bit 5 drives the output-low select and bit 4 drives the narrow-dither select. Address bit 3 is the commit-policy bit, and address bits 2:0 form the target address.
- R6: When the commit-policy bit is 0, a write to 02h copies the new value into the prescaler image.
- R7: When the commit-policy bit is 1, a write to 02h changes only the working register and does not start a store write. A pointer byte of 3Fh copies both registers into the image.
- R8: A write to 0Dh is copied into the address image at once, whatever the commit-policy bit is.
- R9: Every commit keeps the store busy for COMMIT_CYCLES clock cycles. During that time, address and data bytes are answered with NACK and their data is discarded.
- R10: A START or STOP detected in the middle of a byte abandons that byte without writing it. A repeated START keeps the pointer.
- R11: The SDA pull-down changes state only after SCL has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| out_low_o | output | 1 | Prescaler bit 5: powered-down output level select |
| dither_narrow_o | output | 1 | Prescaler bit 4: narrow dither depth select |
| div_exp_o | output | 4 | Divider exponent, clamped to 8 |
| defer_commit_o | output | 1 | Commit-policy bit (1 = commit only on command) |
| dev_sel_o | output | 3 | Target address bits 2:0 |
| nv_busy_o | output | 1 | Store write in progress |
| nv_psc_o | output | 8 | Prescaler store image, read format |
| nv_adr_o | output | 8 | Address store image, read format |

## Verification
A vector table writes and then reads back several prescaler values, including a divider code above the clamp, a value with the don't-care bits set, and a write to an unmapped pointer. The readback shows the stored field width, while the store image shows whether the auto-commit happened. Directed sequences then cover the following:
- Address bytes with a wrong prefix and with wrong low bits, which separates prefix matching from register matching.
- Deferred writes followed by the commit command, which separates the working register from the store image.
- A second byte sent inside the busy window, which separates an accepted write from a refused one.
- A byte cut short by STOP, a change of target address, and a reset in the middle of a run.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1011;
  localparam logic [7:0] PTR_PSC    = 8'h02;
  localparam logic [7:0] PTR_ADR    = 8'h0D;
  localparam logic [7:0] PTR_COMMIT = 8'h3F;
  localparam int unsigned PSC_W     = 6;
  localparam int unsigned ADR_W     = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_ACK_SET, ST_ACK_HOLD,
    ST_TX, ST_TX_REL, ST_TX_MACK, ST_TX_LOAD, ST_IGNORE
  } xfer_st_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic scl;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s, sda_s;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_sh <= '1;
        sda_sh <= '1;
      end else begin
        scl_sh <= scl_i;
        sda_sh <= sda_i;
      end
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_sh <= '1;
        sda_sh <= '1;
      end else begin
        scl_sh <= {scl_sh[STAGES-2:0], scl_i};
        sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      end
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    ev_o.start = scl_s & scl_d & sda_d & ~sda_s;
    ev_o.stop  = scl_s & scl_d & ~sda_d & sda_s;
    ev_o.rise  = scl_s & ~scl_d;
    ev_o.fall  = ~scl_s & scl_d;
    ev_o.scl   = scl_s;
    ev_o.sda   = sda_s;
  end
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import cfg_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bus_ev_t    ev_i,
  input  logic       busy_i,
  input  logic [2:0] dev_sel_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       cmd_o,
  output logic       sda_pull_o
);
  xfer_st_e   st_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q, tx_q, ptr_q;
  logic       pull_q, ack_q, rd_q, ptr_ph_q, addr_ph_q;
  logic [7:0] byte_w;
  logic       addr_hit, byte_done;

  assign byte_w    = {sh_q[6:0], ev_i.sda};
  assign addr_hit  = (byte_w[7:4] == DEV_PREFIX) && (byte_w[3:1] == dev_sel_i);
  assign byte_done = (st_q == ST_RX) && ev_i.rise && (bit_q == 3'd7)
                     && !ev_i.start && !ev_i.stop;

  assign wr_en_o    = byte_done && !addr_ph_q && !ptr_ph_q && !busy_i;
  assign wr_data_o  = byte_w;
  assign cmd_o      = byte_done && !addr_ph_q && ptr_ph_q && !busy_i
                      && (byte_w == PTR_COMMIT);
  assign ptr_o      = ptr_q;
  assign sda_pull_o = pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      pull_q    <= 1'b0;
      ack_q     <= 1'b0;
      rd_q      <= 1'b0;
      ptr_ph_q  <= 1'b0;
      addr_ph_q <= 1'b0;
    end else if (ev_i.start) begin
      st_q      <= ST_RX;
      bit_q     <= '0;
      addr_ph_q <= 1'b1;
      pull_q    <= 1'b0;
    end else if (ev_i.stop) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: if (ev_i.rise) begin
          sh_q  <= byte_w;
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            st_q <= ST_ACK_SET;
            if (addr_ph_q) begin
              addr_ph_q <= 1'b0;
              ack_q     <= addr_hit && !busy_i;
              rd_q      <= byte_w[0];
              ptr_ph_q  <= !byte_w[0];
            end else if (ptr_ph_q) begin
              ack_q <= !busy_i;
              if (!busy_i) begin
                ptr_q    <= byte_w;
                ptr_ph_q <= 1'b0;
              end
            end else begin
              ack_q <= !busy_i;
              if (!busy_i) ptr_q <= ptr_q + 8'd1;
            end
          end
        end
        ST_ACK_SET: if (ev_i.fall) begin
          if (ack_q) begin
            pull_q <= 1'b1;
            st_q   <= ST_ACK_HOLD;
          end else begin
            st_q <= ST_IGNORE;
          end
        end
        ST_ACK_HOLD: if (ev_i.fall) begin
          bit_q <= '0;
          if (rd_q) begin
            pull_q <= ~rd_data_i[7];
            tx_q   <= {rd_data_i[6:0], 1'b0};
            st_q   <= ST_TX;
          end else begin
            pull_q <= 1'b0;
            st_q   <= ST_RX;
          end
        end
        ST_TX: begin
          if (ev_i.fall) begin
            pull_q <= ~tx_q[7];
            tx_q   <= {tx_q[6:0], 1'b0};
          end
          if (ev_i.rise) begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) st_q <= ST_TX_REL;
          end
        end
        ST_TX_REL: if (ev_i.fall) begin
          pull_q <= 1'b0;
          st_q   <= ST_TX_MACK;
        end
        ST_TX_MACK: if (ev_i.rise) begin
          if (!ev_i.sda) begin
            ptr_q <= ptr_q + 8'd1;
            st_q  <= ST_TX_LOAD;
          end else begin
            st_q <= ST_IGNORE;
          end
        end
        ST_TX_LOAD: if (ev_i.fall) begin
          pull_q <= ~rd_data_i[7];
          tx_q   <= {rd_data_i[6:0], 1'b0};
          bit_q  <= '0;
          st_q   <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  AST_PULL_AFTER_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_q != $past(pull_q)) |-> !$past(ev_i.scl)); // R11

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_IGNORE || st_q == ST_RX) |-> !pull_q); // R2
endmodule

// File: rtl/cfg_nv_regs.sv
module cfg_nv_regs
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned      COMMIT_CYCLES = 1000,
  parameter logic [PSC_W-1:0] PSC_RESET     = '0,
  parameter logic [ADR_W-1:0] ADR_RESET     = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       ptr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             cmd_i,
  output logic [7:0]       rd_data_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [ADR_W-1:0] adr_o,
  output logic [PSC_W-1:0] nv_psc_o,
  output logic [ADR_W-1:0] nv_adr_o,
  output logic             busy_o
);
  localparam int unsigned CW = $clog2(COMMIT_CYCLES + 1);

  logic [PSC_W-1:0] psc_q, nv_psc_q;
  logic [ADR_W-1:0] adr_q, nv_adr_q;
  logic [CW-1:0]    cnt_q;
  logic wr_psc, wr_adr, psc_commit, adr_commit, defer;
  logic unused_hi;

  assign unused_hi  = ^wr_data_i[7:PSC_W];
  assign defer      = adr_q[ADR_W-1];
  assign wr_psc     = wr_en_i && (ptr_i == PTR_PSC);
  assign wr_adr     = wr_en_i && (ptr_i == PTR_ADR);
  assign psc_commit = (wr_psc && !defer) || cmd_i;
  assign adr_commit = wr_adr || cmd_i;

  // working registers start from the store image they were loaded from
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_psc_q <= PSC_RESET;
      nv_adr_q <= ADR_RESET;
      psc_q    <= PSC_RESET;
      adr_q    <= ADR_RESET;
      cnt_q    <= '0;
    end else begin
      if (wr_psc) psc_q <= wr_data_i[PSC_W-1:0];
      if (wr_adr) adr_q <= wr_data_i[ADR_W-1:0];
      if (psc_commit) nv_psc_q <= cmd_i ? psc_q : wr_data_i[PSC_W-1:0];
      if (adr_commit) nv_adr_q <= cmd_i ? adr_q : wr_data_i[ADR_W-1:0];
      if (psc_commit || adr_commit) cnt_q <= CW'(COMMIT_CYCLES);
      else if (cnt_q != '0)         cnt_q <= cnt_q - CW'(1);
    end
  end

  always_comb begin
    unique case (ptr_i)
      PTR_PSC: rd_data_o = {{(8-PSC_W){1'b1}}, psc_q};
      PTR_ADR: rd_data_o = {{(8-ADR_W){1'b1}}, adr_q};
      default: rd_data_o = 8'hFF;
    endcase
  end

  assign busy_o   = (cnt_q != '0);
  assign psc_o    = psc_q;
  assign adr_o    = adr_q;
  assign nv_psc_o = nv_psc_q;
  assign nv_adr_o = nv_adr_q;

  AST_NO_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(wr_en_i || cmd_i)); // R9

  AST_AUTO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_psc && !defer) |=> nv_psc_q == $past(wr_data_i[PSC_W-1:0])); // R6

  AST_DEFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_psc && defer) |=> nv_psc_q == $past(nv_psc_q)); // R7

  AST_ADDR_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_adr |=> nv_adr_q == $past(wr_data_i[ADR_W-1:0])); // R8

  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psc_commit || adr_commit) |=> busy_o); // R9
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES   = 2,
  parameter int unsigned      COMMIT_CYCLES = 1000,
  parameter int unsigned      DIV_MAX       = 8,
  parameter logic [PSC_W-1:0] PSC_RESET     = '0,
  parameter logic [ADR_W-1:0] ADR_RESET     = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       out_low_o,
  output logic       dither_narrow_o,
  output logic [3:0] div_exp_o,
  output logic       defer_commit_o,
  output logic [2:0] dev_sel_o,
  output logic       nv_busy_o,
  output logic [7:0] nv_psc_o,
  output logic [7:0] nv_adr_o
);
  bus_ev_t          ev;
  logic [7:0]       ptr, wr_data, rd_data;
  logic             wr_en, cmd, busy;
  logic [PSC_W-1:0] psc, nv_psc;
  logic [ADR_W-1:0] adr, nv_adr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  i2c_xfer_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .busy_i    (busy),
    .dev_sel_i (adr[2:0]),
    .rd_data_i (rd_data),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .cmd_o     (cmd),
    .sda_pull_o(sda_pull_o)
  );

  cfg_nv_regs #(
    .COMMIT_CYCLES(COMMIT_CYCLES),
    .PSC_RESET    (PSC_RESET),
    .ADR_RESET    (ADR_RESET)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ptr_i    (ptr),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .cmd_i    (cmd),
    .rd_data_o(rd_data),
    .psc_o    (psc),
    .adr_o    (adr),
    .nv_psc_o (nv_psc),
    .nv_adr_o (nv_adr),
    .busy_o   (busy)
  );

  assign div_exp_o       = (psc[3:0] > 4'(DIV_MAX)) ? 4'(DIV_MAX) : psc[3:0];
  assign out_low_o       = psc[5];
  assign dither_narrow_o = psc[4];
  assign defer_commit_o  = adr[3];
  assign dev_sel_o       = adr[2:0];
  assign nv_busy_o       = busy;
  assign nv_psc_o        = {{(8-PSC_W){1'b1}}, nv_psc};
  assign nv_adr_o        = {{(8-ADR_W){1'b1}}, nv_adr};
endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull, out_low, dither_narrow, defer_commit, nv_busy;
  logic [3:0] div_exp;
  logic [2:0] dev_sel;
  logic [7:0] nv_psc, nv_adr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  cfg_i2c_target u_cfg_i2c_target (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .out_low_o(out_low), .dither_narrow_o(dither_narrow),
    .div_exp_o(div_exp), .defer_commit_o(defer_commit), .dev_sel_o(dev_sel),
    .nv_busy_o(nv_busy), .nv_psc_o(nv_psc), .nv_adr_o(nv_adr)
  );

  // {pointer, write data, expected readback, expected prescaler image}
  localparam logic [31:0] VEC [0:4] = '{
    32'h02_00_C0_C0, 32'h02_3F_FF_FF, 32'h02_25_E5_E5,
    32'h02_D9_D9_D9, 32'h05_55_FF_D9
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(10); sda_m = 1'b0; wt(10); scl_m = 1'b0; wt(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(10); scl_m = 1'b1; wt(10); sda_m = 1'b1; wt(20);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(10); scl_m = 1'b1; wt(20); scl_m = 1'b0; wt(10);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(10); ack = ~sda_bus; wt(10); scl_m = 1'b0; wt(10);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(10); d[i] = sda_bus; wt(10); scl_m = 1'b0; wt(10);
    end
    sda_m = ~mack; wt(10); scl_m = 1'b1; wt(20); scl_m = 1'b0; wt(10); sda_m = 1'b1;
  endtask

  task automatic xfer_wr(input logic [7:0] dev, input logic [7:0] ptr, input logic [7:0] d0,
                         input logic [7:0] d1, input int nd, output logic [3:0] acks);
    acks = '0;
    bus_start();
    send_byte(dev, acks[0]);
    send_byte(ptr, acks[1]);
    if (nd > 0) send_byte(d0, acks[2]);
    if (nd > 1) send_byte(d1, acks[3]);
    bus_stop();
  endtask

  task automatic xfer_rd(input logic [7:0] dev, input logic [7:0] ptr, input int nb,
                         output logic [7:0] d0, output logic [7:0] d1, output logic ak);
    logic a1, a2;
    bus_start();
    send_byte(dev, ak);
    send_byte(ptr, a1);
    bus_start();
    send_byte(dev | 8'h01, a2);
    ak = ak & a1 & a2;
    d1 = 8'hFF;
    get_byte(d0, nb > 1);
    if (nb > 1) get_byte(d1, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] acks;
    logic [7:0] r0, r1;
    logic ak;
    wt(5); rst_ni = 1'b1; wt(5);

    // R1 reset state
    chk("R1 psc image", nv_psc, 8'hC0);
    chk("R1 adr image", nv_adr, 8'hF0);
    chk("R1 busy", {7'd0, nv_busy}, 8'h00);
    chk("R1 sda released", {7'd0, sda_pull}, 8'h00);
    chk("R1 dev_sel", {5'd0, dev_sel}, 8'h00);

    // R3 R4 R6 table walk
    for (int v = 0; v < 5; v++) begin
      xfer_wr(8'hB0, VEC[v][31:24], VEC[v][23:16], 8'h00, 1, acks);
      chk("R3 write acks", {4'd0, acks}, 8'h07);
      wt(1100);
      xfer_rd(8'hB0, VEC[v][31:24], 1, r0, r1, ak);
      chk("R4 readback", r0, VEC[v][15:8]);
      chk("R6 auto commit image", nv_psc, VEC[v][7:0]);
    end

    // R5 decode: code 9 clamps to 8
    chk("R5 div clamp", {4'd0, div_exp}, 8'h08);
    chk("R5 dither bit4", {7'd0, dither_narrow}, 8'h01);
    chk("R5 out_low bit5", {7'd0, out_low}, 8'h00);
    xfer_wr(8'hB0, 8'h02, 8'h27, 8'h00, 1, acks);
    wt(1100);
    chk("R5 div 7", {4'd0, div_exp}, 8'h07);
    chk("R5 out_low set", {7'd0, out_low}, 8'h01);
    chk("R5 dither clear", {7'd0, dither_narrow}, 8'h00);

    // R2 address mismatch
    xfer_wr(8'hB2, 8'h02, 8'h00, 8'h00, 1, acks);
    chk("R2 low-bit mismatch nack", {7'd0, acks[0]}, 8'h00);
    xfer_wr(8'hA0, 8'h02, 8'h00, 8'h00, 1, acks);
    chk("R2 prefix mismatch nack", {7'd0, acks[0]}, 8'h00);
    xfer_rd(8'hB0, 8'h02, 1, r0, r1, ak);
    chk("R2 mismatch wrote nothing", r0, 8'hE7);

    // R8 address register commits although deferral gets enabled
    xfer_wr(8'hB0, 8'h0D, 8'h08, 8'h00, 1, acks);
    chk("R8 adr image immediate", nv_adr, 8'hF8);
    chk("R9 busy after commit", {7'd0, nv_busy}, 8'h01);
    wt(1100);
    chk("R5 defer bit", {7'd0, defer_commit}, 8'h01);

    // R7 deferred prescaler write
    xfer_wr(8'hB0, 8'h02, 8'h12, 8'h00, 1, acks);
    chk("R7 deferred write acked", {4'd0, acks}, 8'h07);
    chk("R7 image untouched", nv_psc, 8'hE7);
    chk("R7 no store write", {7'd0, nv_busy}, 8'h00);
    xfer_rd(8'hB0, 8'h02, 1, r0, r1, ak);
    chk("R7 working reg", r0, 8'hD2);

    // R3 sequential write crossing unmapped 01h
    xfer_wr(8'hB0, 8'h01, 8'hAA, 8'h2B, 2, acks);
    chk("R3 sequential acks", {4'd0, acks}, 8'h0F);
    xfer_rd(8'hB0, 8'h02, 2, r0, r1, ak);
    chk("R4 sequential byte0", r0, 8'hEB);
    chk("R4 sequential byte1 unmapped", r1, 8'hFF);
    chk("R7 image still old", nv_psc, 8'hE7);

    // R7 commit command
    xfer_wr(8'hB0, 8'h3F, 8'h00, 8'h00, 0, acks);
    chk("R7 command acked", {4'd0, acks}, 8'h03);
    chk("R7 command copies psc", nv_psc, 8'hEB);
    chk("R7 command busy", {7'd0, nv_busy}, 8'h01);

    // R9 refused while busy
    xfer_wr(8'hB0, 8'h02, 8'h00, 8'h00, 1, acks);
    chk("R9 address nack busy", {7'd0, acks[0]}, 8'h00);
    wt(1100);
    xfer_rd(8'hB0, 8'h02, 1, r0, r1, ak);
    chk("R9 busy write discarded", r0, 8'hEB);

    // R9 second byte inside busy window, auto-commit mode
    xfer_wr(8'hB0, 8'h0D, 8'h00, 8'h00, 1, acks);
    wt(1100);
    xfer_wr(8'hB0, 8'h02, 8'h01, 8'h02, 2, acks);
    chk("R9 first data ack", {7'd0, acks[2]}, 8'h01);
    chk("R9 second data nack", {7'd0, acks[3]}, 8'h00);
    wt(1100);
    xfer_rd(8'hB0, 8'h02, 1, r0, r1, ak);
    chk("R9 second byte discarded", r0, 8'hC1);
    chk("R6 auto commit", nv_psc, 8'hC1);

    // R2 address change
    xfer_wr(8'hB0, 8'h0D, 8'h05, 8'h00, 1, acks);
    wt(1100);
    chk("R8 new adr image", nv_adr, 8'hF5);
    xfer_rd(8'hB0, 8'h02, 1, r0, r1, ak);
    chk("R2 old address refused", {7'd0, ak}, 8'h00);
    xfer_rd(8'hBA, 8'h02, 1, r0, r1, ak);
    chk("R2 new address acked", {7'd0, ak}, 8'h01);
    chk("R10 pointer kept over repeated start", r0, 8'hC1);

    // R10 STOP mid byte
    bus_start();
    send_byte(8'hBA, ak);
    send_byte(8'h02, ak);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    xfer_rd(8'hBA, 8'h02, 1, r0, r1, ak);
    chk("R10 aborted byte not written", r0, 8'hC1);
    chk("R10 no commit", nv_psc, 8'hC1);

    // R1 reset mid-run
    rst_ni = 1'b0; wt(5); rst_ni = 1'b1; wt(5);
    chk("R1 psc image after reset", nv_psc, 8'hC0);
    chk("R1 adr image after reset", nv_adr, 8'hF0);
    chk("R1 dev_sel after reset", {5'd0, dev_sel}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule